// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the address for each beat of a four-beat burst into a synchronous memory. When a burst is started, it captures a full base address. Each later advance pulse steps the two lowest address bits through the burst, and the sequence returns to the starting point after four beats. The bits above the burst field are held at their loaded value and pass to the output unchanged.

An order select input sets how the low bits step. In interleaved order, beat n is the starting low bits XOR n. In linear order, beat n is the starting low bits plus n, modulo four. The order select is captured only when a burst starts. A new start in the middle of a burst drops the current burst and begins again from the new base. When neither start nor advance is asserted, the address holds, which lets the surrounding logic insert wait states.

Top module: `burst_addr_gen`

## Requirements
- R1: After reset, before any load, addr_o is all zeros.
- R2: On the cycle after a clock edge with load_i high, addr_o equals the base_i sampled at that edge. load_i takes priority over adv_i in the same cycle.
- R3: When mode_i was 1 at load (interleaved), after n advances the low two bits of addr_o equal the loaded low bits XOR n. For example, a start of 01 gives 01, 00, 11, 10.
- R4: When mode_i was 0 at load (linear), after n advances the low two bits of addr_o equal the loaded low bits plus n, modulo 4. For example, a start of 01 gives 01, 10, 11, 00.
- R5: The fourth advance after a load brings addr_o back to the loaded address.
- R6: A cycle with load_i and adv_i both low leaves addr_o unchanged.
- R7: A load during a burst drops the old burst. Counting restarts at beat 0 from the new base.
- R8: addr_o bits above bit 1 equal the loaded base bits and are not changed by advances.
- R9: mode_i matters only at a load edge. A change of mode_i during a burst does not alter the ongoing sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | Start a burst from base_i |
| adv_i | input | 1 | Step to the next burst beat |
| mode_i | input | 1 | Order select at load: 1 interleaved, 0 linear |
| base_i | input | ADDR_W (18) | Starting address of a burst |
| addr_o | output | ADDR_W (18) | Current burst address |

## Verification
Directed bursts from start offset 01 are run in both orders. At that offset the interleaved and linear sequences differ on beats 1 and 3, so a mapping that uses the wrong order is exposed. Back-to-back loads with advance asserted at the same time show whether load wins. A flip of the order select during a burst shows whether the order was captured only at load. Several thousand random cycles then mix loads, advances and idle cycles across all four start offsets and random upper bits, and each cycle is compared with a bench model of the sequence.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;
   typedef enum logic {
      ORD_LINEAR     = 1'b0,
      ORD_INTERLEAVE = 1'b1
   } order_e;

   // Order variant choices for the ORDER parameter
   localparam int ORDER_SELECTABLE = 0;
   localparam int ORDER_FIXED_XOR  = 1;
   localparam int ORDER_FIXED_LIN  = 2;
endpackage

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
   parameter int BEAT_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              step_i,
   output logic [BEAT_W-1:0] beat_o
);
   localparam logic [BEAT_W-1:0] LAST_BEAT = {BEAT_W{1'b1}};

   if (BEAT_W < 1) begin : g_bad_width
      $error("burst_beat_ctr: BEAT_W must be at least 1");
   end

   logic [BEAT_W-1:0] beat_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      beat_q <= '0;
      else if (clr_i)  beat_q <= '0;
      else if (step_i) beat_q <= beat_q + 1'b1;
   end

   assign beat_o = beat_q;

   // R5
   wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && step_i && beat_q == LAST_BEAT) |=> (beat_q == '0));

   // R7
   clear_on_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (beat_q == '0));
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
   import burst_addr_pkg::*;
#(
   parameter int BEAT_W = 2
) (
   input  logic [BEAT_W-1:0] start_i,
   input  logic [BEAT_W-1:0] beat_i,
   input  order_e            order_i,
   output logic [BEAT_W-1:0] lo_o
);
   logic [BEAT_W-1:0] xor_lo;
   logic [BEAT_W-1:0] sum_lo;

   for (genvar b = 0; b < BEAT_W; b++) begin : g_xor_bit
      assign xor_lo[b] = start_i[b] ^ beat_i[b];
   end

   assign sum_lo = start_i + beat_i;

   always_comb begin
      lo_o = (order_i == ORD_INTERLEAVE) ? xor_lo : sum_lo;
   end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
   import burst_addr_pkg::*;
#(
   parameter int ADDR_W = 18,
   parameter int BEAT_W = 2,
   parameter int ORDER  = ORDER_SELECTABLE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic              adv_i,
   input  logic              mode_i,
   input  logic [ADDR_W-1:0] base_i,
   output logic [ADDR_W-1:0] addr_o
);
   localparam int HI_W = ADDR_W - BEAT_W;

   if (ADDR_W <= BEAT_W) begin : g_bad_addr
      $error("burst_addr_gen: ADDR_W must exceed BEAT_W");
   end
   if (ORDER < 0 || ORDER > 2) begin : g_bad_order
      $error("burst_addr_gen: ORDER must be 0, 1 or 2");
   end

   logic [HI_W-1:0]   hi_q;
   logic [BEAT_W-1:0] start_q;
   order_e            order_q;
   order_e            order_d;
   logic [BEAT_W-1:0] beat;
   logic [BEAT_W-1:0] lo;

   // Order chosen by the variant parameter
   if (ORDER == ORDER_FIXED_XOR) begin : g_fix_xor
      assign order_d = ORD_INTERLEAVE;
   end else if (ORDER == ORDER_FIXED_LIN) begin : g_fix_lin
      assign order_d = ORD_LINEAR;
   end else begin : g_sel
      assign order_d = order_e'(mode_i);
   end

   // Base and order are captured only when a burst starts
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q    <= '0;
         start_q <= '0;
         order_q <= ORD_INTERLEAVE;
      end else if (load_i) begin
         hi_q    <= base_i[ADDR_W-1:BEAT_W];
         start_q <= base_i[BEAT_W-1:0];
         order_q <= order_d;
      end
   end

   burst_beat_ctr #(.BEAT_W(BEAT_W)) u_beat (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (load_i),
      .step_i (adv_i),
      .beat_o (beat)
   );

   burst_order_map #(.BEAT_W(BEAT_W)) u_map (
      .start_i (start_q),
      .beat_i  (beat),
      .order_i (order_q),
      .lo_o    (lo)
   );

   assign addr_o = {hi_q, lo};

   // R2
   load_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (addr_o == $past(base_i)));

   // R6
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && !adv_i) |=> $stable(addr_o));

   // R8
   upper_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> $stable(addr_o[ADDR_W-1:BEAT_W]));

   // R4
   linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && adv_i && order_q == ORD_LINEAR)
      |=> (addr_o[BEAT_W-1:0] == $past(addr_o[BEAT_W-1:0]) + 1'b1));

   // R9
   order_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> $stable(order_q));
endmodule

// File: tb/burst_addr_gen_test.sv
`timescale 1ns/1ps
module burst_addr_gen_test;
   localparam int AW = 18;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          load_i = 1'b0;
   logic          adv_i = 1'b0;
   logic          mode_i = 1'b1;
   logic [AW-1:0] base_i = '0;
   logic [AW-1:0] addr_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // model state
   logic [AW-1:0] m_base = '0;
   logic [1:0]    m_beat = 2'd0;
   logic          m_mode = 1'b1;

   always #2.5 clk = ~clk;

   burst_addr_gen #(.ADDR_W(AW)) uut (
      .clk(clk), .rst_n(rst_n), .load_i(load_i), .adv_i(adv_i),
      .mode_i(mode_i), .base_i(base_i), .addr_o(addr_o)
   );

   function automatic logic [AW-1:0] model_addr(logic [AW-1:0] b, logic [1:0] n, logic md);
      logic [1:0] lo;
      lo = md ? (b[1:0] ^ n) : (b[1:0] + n);
      return {b[AW-1:2], lo};
   endfunction

   task automatic check(string req, logic [AW-1:0] exp);
      checks++;
      if (addr_o !== exp) begin
         fails++;
         $display("FAIL %s: addr_o=%h expected=%h", req, addr_o, exp);
      end
   endtask

   // Apply one cycle of inputs, update the model, check after the edge.
   task automatic cyc(string req, logic ld, logic av, logic md, logic [AW-1:0] b);
      load_i = ld; adv_i = av; mode_i = md; base_i = b;
      @(posedge clk);
      if (ld) begin
         m_base = b; m_beat = 2'd0; m_mode = md;
      end else if (av) begin
         m_beat = m_beat + 2'd1;
      end
      @(negedge clk);
      check(req, model_addr(m_base, m_beat, m_mode));
   endtask

   initial begin
      logic [AW-1:0] b0;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      check("R1", '0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", '0);

      // R3 interleaved from 01: 01 00 11 10 then R5 wrap
      b0 = 18'h2A5C1;
      cyc("R2", 1'b1, 1'b0, 1'b1, b0);
      cyc("R3", 1'b0, 1'b1, 1'b1, '0); check("R3", {b0[AW-1:2], 2'b00});
      cyc("R3", 1'b0, 1'b1, 1'b1, '0); check("R3", {b0[AW-1:2], 2'b11});
      cyc("R3", 1'b0, 1'b1, 1'b1, '0); check("R3", {b0[AW-1:2], 2'b10});
      cyc("R5", 1'b0, 1'b1, 1'b1, '0); check("R5", b0);

      // R4 linear from 01: 01 10 11 00, R9 mode flips ignored mid-burst
      b0 = 18'h15551;
      cyc("R2", 1'b1, 1'b0, 1'b0, b0);
      cyc("R4", 1'b0, 1'b1, 1'b1, '0); check("R9", {b0[AW-1:2], 2'b10});
      cyc("R4", 1'b0, 1'b1, 1'b0, '0); check("R4", {b0[AW-1:2], 2'b11});
      cyc("R6", 1'b0, 1'b0, 1'b1, 18'h3FFFF); check("R6", {b0[AW-1:2], 2'b11});
      cyc("R4", 1'b0, 1'b1, 1'b1, '0); check("R8", {b0[AW-1:2], 2'b00});
      cyc("R5", 1'b0, 1'b1, 1'b0, '0); check("R5", b0);

      // R7 mid-burst reload, load beats advance in same cycle (R2)
      cyc("R3", 1'b1, 1'b0, 1'b1, 18'h00002);
      cyc("R3", 1'b0, 1'b1, 1'b1, '0);
      cyc("R7", 1'b1, 1'b1, 1'b0, 18'h3FF03); check("R7", 18'h3FF03);
      cyc("R4", 1'b0, 1'b1, 1'b1, '0); check("R4", 18'h3FF00);

      // random mix
      for (int i = 0; i < 4000; i++) begin
         logic ld, av, md;
         ld = ($urandom_range(99) < 15);
         av = ($urandom_range(99) < 55);
         md = $urandom_range(1);
         cyc(ld ? "R2" : (av ? (m_mode ? "R3" : "R4") : "R6"),
             ld, av, md, AW'($urandom));
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #(100000 * 5);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: expected=done actual=hung");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule